// File: doc/BRIEF.md
# SMT Fetch Thread Arbiter

This block decides, every cycle, which hardware threads of a simultaneous multithreaded core may fetch and how many fetch slots each one gets. It keeps three saturating counters per thread: instructions fetched but not yet issued (front-end occupancy), outstanding L2 load plus TLB misses, and reorder-buffer entries held. The fetch stage, decode logic and the miss-tracking structures pulse increment and decrement strobes into these counters. The arbiter answers with a grant mask and a slot count.

Two families of policy are offered. In the count-priority mode a single thread gets the whole fetch width. The winner is the valid thread with the fewest front-end instructions. Ties are broken in rotating order, and a starvation guard forces a grant to any thread that has waited too long. In the three static modes, groups of one, two or four threads rotate round-robin and split the fetch width evenly.

A per-thread throttle unit watches the miss and reorder-buffer counters against programmable thresholds. When a thread is congested, the throttle unit applies the action selected by a shared action field. Every action above "off" lowers the thread's priority. The stronger actions also hold the thread's decode. The strongest action adds a one-cycle request to flush the thread's instructions that are waiting for dispatch.

Top module: `smt_fetch_arbiter`

## Requirements
- R1: With `mode` = 0 (count priority), `fetch_grant` is one-hot on the valid thread with the smallest front-end count, and `fetch_slots` equals the fetch width (8).
- R2: In count priority, equal candidates are resolved by taking the first one in increasing thread order after the last granted thread (modulo 4). After reset, the last granted thread is thread 3.
- R3: Static modes are encoded as follows. `mode` = 1 grants one thread with 8 slots, rotating 0,1,2,3. `mode` = 2 grants the pair {0,1} and then the pair {2,3} alternately, with 4 slots each. `mode` = 3 grants all four threads with 2 slots each. Rotation starts at thread 0 after reset, and a thread whose `thr_valid` bit is low is never granted.
- R4: Each per-thread counter saturates at its maximum (63 for front-end counts) and at 0, and an increment together with a decrement in the same cycle leaves the count unchanged.
- R5: A thread is congested when its miss count is greater than or equal to `miss_thr`, or when its reorder-buffer count is strictly greater than `rob_thr`. Counts take effect the cycle after the strobe.
- R6: With `thr_act` ≥ 1, a congested thread shows `prio_low`. In count priority, a thread with `prio_low` set is granted only if every valid thread has `prio_low` set.
- R7: With `thr_act` ≥ 2, a congested thread also shows `decode_block`. The signal clears once the congestion clears.
- R8: With `thr_act` = 3, `flush_req` pulses for exactly one cycle, in the first cycle a thread becomes congested, while `decode_block` stays set.
- R9: In count priority, a valid thread that has gone 16 consecutive cycles without a grant is granted in the next cycle regardless of its count. Its wait counter clears while it is not in count-priority mode.
- R10: When no thread is valid, or out of reset, `fetch_grant` and `fetch_slots` are 0. After reset, all throttle outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 count priority, 1/2/3 static groups of 1/2/4 |
| thr_valid | input | 4 | Thread may fetch |
| fe_inc | input | 4 | Front-end count increment strobes |
| fe_dec | input | 4 | Front-end count decrement strobes |
| miss_inc | input | 4 | New L2 load or TLB miss strobes |
| miss_dec | input | 4 | Miss resolved strobes |
| rob_inc | input | 4 | Reorder-buffer entry allocated strobes |
| rob_dec | input | 4 | Reorder-buffer entry released strobes |
| miss_thr | input | 4 | Miss congestion threshold |
| rob_thr | input | 7 | Reorder-buffer congestion threshold |
| thr_act | input | 2 | Throttle action: 0 off, 1 lower, 2 block decode, 3 flush and block |
| fetch_grant | output | 4 | Threads allowed to fetch this cycle |
| fetch_slots | output | 4 | Fetch slots for each granted thread |
| prio_low | output | 4 | Thread priority lowered |
| decode_block | output | 4 | Thread decode inhibited |
| flush_req | output | 4 | Flush of a thread's waiting instructions requested |

## Verification
The hardest situation to reach is the starvation guard. The stimulus has to hold one thread at a lower count than another for sixteen consecutive count-priority cycles, without the waiting thread ever winning a tie. The bench first loads the counters while in a static mode, because that keeps the wait counters clear. It then switches to count priority and samples every cycle until the forced grant. The single-cycle flush pulse is equally narrow. The bench holds one thread congested from earlier steps and drives the reorder-buffer count of the other thread through its threshold one entry at a time. It then checks that only the newly congested thread pulses, and only once.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

   typedef enum logic [1:0] {
      MODE_ICNT = 2'd0,
      MODE_RR1  = 2'd1,
      MODE_RR2  = 2'd2,
      MODE_RR4  = 2'd3
   } fetch_mode_e;

   typedef enum logic [1:0] {
      ACT_OFF   = 2'd0,
      ACT_LOWER = 2'd1,
      ACT_BLOCK = 2'd2,
      ACT_FLUSH = 2'd3
   } throttle_act_e;

endpackage

// File: rtl/sfa_sat_cnt.sv
module sfa_sat_cnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   if (W < 1) begin : g_chk_w
      $error("sfa_sat_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc && !dec && cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end else if (dec && !inc && cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && inc) |=> cnt == CNT_MAX); // R4
   AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && dec) |=> $stable(cnt)); // R4

endmodule

// File: rtl/sfa_throttle.sv
module sfa_throttle
   import sfa_pkg::*;
#(
   parameter int MISS_W = 4,
   parameter int ROB_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MISS_W-1:0] miss_cnt,
   input  logic [ROB_W-1:0]  rob_cnt,
   input  logic [MISS_W-1:0] miss_thr,
   input  logic [ROB_W-1:0]  rob_thr,
   input  logic [1:0]        act,
   output logic              prio_low,
   output logic              dec_block,
   output logic              flush_req
);
   logic cong;
   logic cong_q;

   assign cong = (miss_cnt >= miss_thr) || (rob_cnt > rob_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cong_q <= 1'b0;
      else        cong_q <= cong;
   end

   always_comb begin
      prio_low  = cong && (act != ACT_OFF);
      dec_block = cong && (act == ACT_BLOCK || act == ACT_FLUSH);
      flush_req = cong && !cong_q && (act == ACT_FLUSH);
   end

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !flush_req); // R8

endmodule

// File: rtl/sfa_icnt_pick.sv
module sfa_icnt_pick #(
   parameter int N  = 4,
   parameter int KW = 7
) (
   input  logic [N-1:0]         elig,
   input  logic [N-1:0][KW-1:0] key,
   input  logic [$clog2(N)-1:0] last,
   output logic [N-1:0]         pick
);
   logic          found;
   logic [KW-1:0] best;
   int            bidx;

   always_comb begin
      pick  = '0;
      found = 1'b0;
      best  = '1;
      bidx  = 0;
      for (int i = 1; i <= N; i++) begin
         int idx;
         idx = (int'(last) + i) % N;
         if (elig[idx] && (!found || key[idx] < best)) begin
            found = 1'b1;
            best  = key[idx];
            bidx  = idx;
         end
      end
      if (found) pick[bidx] = 1'b1;
   end

endmodule

// File: rtl/sfa_static_rr.sv
module sfa_static_rr #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [1:0]   mode,
   output logic [N-1:0] grp
);
   localparam int IDX_W = $clog2(N);

   logic [IDX_W-1:0] ptr;
   int unsigned      gs_log;
   int unsigned      base;
   int unsigned      nxt;

   always_comb begin
      gs_log = (mode == 2'd0) ? 0 : int'(mode) - 1;
      base   = (int'(ptr) >> gs_log) << gs_log;
      nxt    = (base + (1 << gs_log)) % N;
      for (int j = 0; j < N; j++) begin
         grp[j] = ((j >> gs_log) == (int'(ptr) >> gs_log));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr <= '0;
      else if (en) ptr <= IDX_W'(nxt);
   end

endmodule

// File: rtl/smt_fetch_arbiter.sv
module smt_fetch_arbiter
   import sfa_pkg::*;
#(
   parameter int NTHR       = 4,
   parameter int FETCH_W    = 8,
   parameter int FE_W       = 6,
   parameter int MISS_W     = 4,
   parameter int ROB_W      = 7,
   parameter int STARVE_LIM = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode,
   input  logic [NTHR-1:0]             thr_valid,
   input  logic [NTHR-1:0]             fe_inc,
   input  logic [NTHR-1:0]             fe_dec,
   input  logic [NTHR-1:0]             miss_inc,
   input  logic [NTHR-1:0]             miss_dec,
   input  logic [NTHR-1:0]             rob_inc,
   input  logic [NTHR-1:0]             rob_dec,
   input  logic [MISS_W-1:0]           miss_thr,
   input  logic [ROB_W-1:0]            rob_thr,
   input  logic [1:0]                  thr_act,
   output logic [NTHR-1:0]             fetch_grant,
   output logic [$clog2(FETCH_W+1)-1:0] fetch_slots,
   output logic [NTHR-1:0]             prio_low,
   output logic [NTHR-1:0]             decode_block,
   output logic [NTHR-1:0]             flush_req
);
   localparam int IDX_W  = $clog2(NTHR);
   localparam int SLOT_W = $clog2(FETCH_W + 1);
   localparam int AGE_W  = $clog2(STARVE_LIM + 1);
   localparam int KEY_W  = FE_W + 1;

   if (NTHR < 4 || (NTHR & (NTHR - 1)) != 0) begin : g_chk_nthr
      $error("smt_fetch_arbiter: NTHR must be a power of two, at least 4");
   end
   if (FETCH_W % 4 != 0) begin : g_chk_fw
      $error("smt_fetch_arbiter: FETCH_W must split evenly across four threads");
   end
   if (STARVE_LIM < 1) begin : g_chk_starve
      $error("smt_fetch_arbiter: STARVE_LIM must be positive");
   end

   logic [NTHR-1:0][FE_W-1:0]  fe_cnt;
   logic [NTHR-1:0]            starved;
   logic                       any_starved;
   logic [NTHR-1:0]            ic_elig;
   logic [NTHR-1:0][KEY_W-1:0] ic_key;
   logic [NTHR-1:0]            ic_pick;
   logic [NTHR-1:0]            rr_grp;
   logic [IDX_W-1:0]           last_g;
   logic                       icnt_mode;

   assign icnt_mode = (mode == MODE_ICNT);

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic [MISS_W-1:0] miss_cnt;
      logic [ROB_W-1:0]  rob_cnt;
      logic [AGE_W-1:0]  age;

      sfa_sat_cnt #(.W(FE_W)) u_fe (
         .clk(clk), .rst_n(rst_n), .inc(fe_inc[t]), .dec(fe_dec[t]), .cnt(fe_cnt[t])
      );
      sfa_sat_cnt #(.W(MISS_W)) u_miss (
         .clk(clk), .rst_n(rst_n), .inc(miss_inc[t]), .dec(miss_dec[t]), .cnt(miss_cnt)
      );
      sfa_sat_cnt #(.W(ROB_W)) u_rob (
         .clk(clk), .rst_n(rst_n), .inc(rob_inc[t]), .dec(rob_dec[t]), .cnt(rob_cnt)
      );

      sfa_throttle #(.MISS_W(MISS_W), .ROB_W(ROB_W)) u_thr (
         .clk(clk), .rst_n(rst_n),
         .miss_cnt(miss_cnt), .rob_cnt(rob_cnt),
         .miss_thr(miss_thr), .rob_thr(rob_thr), .act(thr_act),
         .prio_low(prio_low[t]), .dec_block(decode_block[t]), .flush_req(flush_req[t])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age <= '0;
         end else if (!icnt_mode || !thr_valid[t] || fetch_grant[t]) begin
            age <= '0;
         end else if (age != AGE_W'(STARVE_LIM)) begin
            age <= age + 1'b1;
         end
      end

      assign starved[t] = thr_valid[t] && (age == AGE_W'(STARVE_LIM));

      AST_STARVE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
         (icnt_mode && starved[t] && $countones(starved) == 1) |-> fetch_grant[t]); // R9
   end

   assign any_starved = |starved;

   always_comb begin
      for (int t = 0; t < NTHR; t++) begin
         ic_elig[t] = any_starved ? starved[t] : thr_valid[t];
         ic_key[t]  = any_starved ? '0 : {prio_low[t], fe_cnt[t]};
      end
   end

   sfa_icnt_pick #(.N(NTHR), .KW(KEY_W)) u_pick (
      .elig(ic_elig), .key(ic_key), .last(last_g), .pick(ic_pick)
   );

   sfa_static_rr #(.N(NTHR)) u_rr (
      .clk(clk), .rst_n(rst_n), .en(!icnt_mode), .mode(mode), .grp(rr_grp)
   );

   always_comb begin
      if (icnt_mode) begin
         fetch_grant = ic_pick;
         fetch_slots = (|ic_pick) ? SLOT_W'(FETCH_W) : '0;
      end else begin
         fetch_grant = rr_grp & thr_valid;
         fetch_slots = (|(rr_grp & thr_valid)) ? SLOT_W'(FETCH_W >> (mode - 2'd1)) : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_g <= IDX_W'(NTHR - 1);
      end else if (icnt_mode && |fetch_grant) begin
         for (int t = 0; t < NTHR; t++) begin
            if (fetch_grant[t]) last_g <= IDX_W'(t);
         end
      end
   end

   AST_ICNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      icnt_mode |-> $onehot0(fetch_grant)); // R1
   AST_GRANT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_grant & ~thr_valid) == '0); // R3
   AST_LOW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (icnt_mode && !any_starved && |(fetch_grant & prio_low))
         |-> (thr_valid & ~prio_low) == '0); // R6
   AST_IDLE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_valid == '0) |-> (fetch_grant == '0 && fetch_slots == '0)); // R10

endmodule

// File: tb/tb_smt_fetch_arbiter.sv
module tb_smt_fetch_arbiter;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic [3:0] thr_valid, fe_inc, fe_dec, miss_inc, miss_dec, rob_inc, rob_dec;
   logic [3:0] miss_thr;
   logic [6:0] rob_thr;
   logic [1:0] thr_act;
   logic [3:0] fetch_grant, fetch_slots, prio_low, decode_block, flush_req;

   always #10 clk = ~clk;

   smt_fetch_arbiter dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .thr_valid(thr_valid),
      .fe_inc(fe_inc), .fe_dec(fe_dec), .miss_inc(miss_inc), .miss_dec(miss_dec),
      .rob_inc(rob_inc), .rob_dec(rob_dec), .miss_thr(miss_thr), .rob_thr(rob_thr),
      .thr_act(thr_act), .fetch_grant(fetch_grant), .fetch_slots(fetch_slots),
      .prio_low(prio_low), .decode_block(decode_block), .flush_req(flush_req)
   );

   typedef struct {
      logic [3:0] g;
      logic [3:0] s;
      bit         thr;
      logic [3:0] lo;
      logic [3:0] bl;
      logic [3:0] fl;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   n_chk  = 0;
   int   n_fail = 0;

   // monitor: one expected item per cycle, compared away from the clock edge
   always @(negedge clk) begin
      exp_t e;
      if (q.size() > 0) begin
         e = q.pop_front();
         n_chk++;
         if (fetch_grant !== e.g || fetch_slots !== e.s) begin
            n_fail++;
            $display("FAIL %s: grant=%b slots=%0d expected grant=%b slots=%0d",
                     e.tag, fetch_grant, fetch_slots, e.g, e.s);
         end
         if (e.thr) begin
            n_chk++;
            if (prio_low !== e.lo || decode_block !== e.bl || flush_req !== e.fl) begin
               n_fail++;
               $display("FAIL %s: low=%b blk=%b flush=%b expected low=%b blk=%b flush=%b",
                        e.tag, prio_low, decode_block, flush_req, e.lo, e.bl, e.fl);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_g(input logic [3:0] g, input logic [3:0] s, input string tag);
      exp_t e;
      e.g = g; e.s = s; e.thr = 1'b0; e.lo = '0; e.bl = '0; e.fl = '0; e.tag = tag;
      q.push_back(e);
      step();
   endtask

   task automatic expect_t(input logic [3:0] g, input logic [3:0] s, input logic [3:0] lo,
                           input logic [3:0] bl, input logic [3:0] fl, input string tag);
      exp_t e;
      e.g = g; e.s = s; e.thr = 1'b1; e.lo = lo; e.bl = bl; e.fl = fl; e.tag = tag;
      q.push_back(e);
      step();
   endtask

   task automatic fe_pulse(input int t, input int n, input bit up);
      repeat (n) begin
         fe_inc[t] = up; fe_dec[t] = !up;
         step();
         fe_inc = '0; fe_dec = '0;
      end
   endtask

   task automatic miss_pulse(input int t, input int n, input bit up);
      repeat (n) begin
         miss_inc[t] = up; miss_dec[t] = !up;
         step();
         miss_inc = '0; miss_dec = '0;
      end
   endtask

   task automatic rob_pulse(input int t, input int n);
      repeat (n) begin
         rob_inc[t] = 1'b1;
         step();
         rob_inc = '0;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 20);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode = 2'd3; thr_valid = '0;
      fe_inc = '0; fe_dec = '0; miss_inc = '0; miss_dec = '0; rob_inc = '0; rob_dec = '0;
      miss_thr = 4'd3; rob_thr = 7'd5; thr_act = 2'd0;
      repeat (3) step();
      rst_n = 1'b1;

      // R10: reset state, nothing valid
      expect_t(4'b0000, 4'd0, 4'b0000, 4'b0000, 4'b0000, "R10 reset idle");

      // R3: one thread at a time, rotating from thread 0
      mode = 2'd1; thr_valid = 4'b1111;
      expect_g(4'b0001, 4'd8, "R3 rr1 t0");
      expect_g(4'b0010, 4'd8, "R3 rr1 t1");
      expect_g(4'b0100, 4'd8, "R3 rr1 t2");
      expect_g(4'b1000, 4'd8, "R3 rr1 t3");
      // R3: pairs, invalid thread 3 withheld
      mode = 2'd2; thr_valid = 4'b0111;
      expect_g(4'b0011, 4'd4, "R3 rr2 pair01");
      expect_g(4'b0100, 4'd4, "R3 rr2 pair23 masked");
      // R3: all four
      mode = 2'd3; thr_valid = 4'b1011;
      expect_g(4'b1011, 4'd2, "R3 rr4 all");

      // R2: all counts equal, rotation after last granted (3 after reset)
      mode = 2'd0; thr_valid = 4'b1111;
      expect_g(4'b0001, 4'd8, "R2 tie t0");
      expect_g(4'b0010, 4'd8, "R2 tie t1");
      expect_g(4'b0100, 4'd8, "R2 tie t2");
      expect_g(4'b1000, 4'd8, "R2 tie t3");
      mode = 2'd3;

      // R1: fewest front-end instructions wins
      fe_pulse(0, 5, 1'b1);
      fe_pulse(1, 2, 1'b1);
      fe_pulse(2, 7, 1'b1);
      fe_pulse(3, 3, 1'b1);
      mode = 2'd0;
      expect_g(4'b0010, 4'd8, "R1 min count t1");
      mode = 2'd3;

      // R4: simultaneous inc and dec cancel (t1 stays at 2, below t3 at 3)
      repeat (3) begin
         fe_inc[1] = 1'b1; fe_dec[1] = 1'b1;
         step();
         fe_inc = '0; fe_dec = '0;
      end
      mode = 2'd0;
      expect_g(4'b0010, 4'd8, "R4 cancel t1");
      mode = 2'd3;

      // R4: t3 goes 3 + 61 -> saturates at 63, stays above t2 at 7
      fe_pulse(3, 61, 1'b1);
      thr_valid = 4'b1100; mode = 2'd0;
      expect_g(4'b0100, 4'd8, "R4 saturate t3");
      mode = 2'd3;

      // R5/R6: miss threshold 3, lower-priority action
      thr_valid = 4'b0011; thr_act = 2'd1;
      miss_pulse(1, 2, 1'b1);
      expect_t(4'b0011, 4'd2, 4'b0000, 4'b0000, 4'b0000, "R5 below miss threshold");
      miss_pulse(1, 1, 1'b1);
      mode = 2'd0;
      expect_t(4'b0001, 4'd8, 4'b0010, 4'b0000, 4'b0000, "R6 low thread skipped");
      mode = 2'd3;
      miss_pulse(0, 3, 1'b1);
      mode = 2'd0;
      expect_t(4'b0010, 4'd8, 4'b0011, 4'b0000, 4'b0000, "R6 all low, min count");
      mode = 2'd3;

      // R7: decode block while congested, released when cleared
      thr_act = 2'd2;
      expect_t(4'b0011, 4'd2, 4'b0011, 4'b0011, 4'b0000, "R7 block both");
      miss_pulse(1, 1, 1'b0);
      expect_t(4'b0011, 4'd2, 4'b0001, 4'b0001, 4'b0000, "R7 t1 released");

      // R5/R8: reorder-buffer threshold 5 is strict, flush pulses once on entry
      thr_act = 2'd3;
      rob_pulse(1, 5);
      expect_t(4'b0011, 4'd2, 4'b0001, 4'b0001, 4'b0000, "R5 rob at threshold");
      rob_pulse(1, 1);
      expect_t(4'b0011, 4'd2, 4'b0011, 4'b0011, 4'b0010, "R8 flush pulse t1");
      expect_t(4'b0011, 4'd2, 4'b0011, 4'b0011, 4'b0000, "R8 flush ends, block held");

      // R9: t0 (count 5) loses to t1 (count 2) for 16 cycles, then forced
      thr_act = 2'd0; mode = 2'd0;
      for (int i = 0; i < 16; i++) expect_g(4'b0010, 4'd8, "R9 t1 while t0 waits");
      expect_g(4'b0001, 4'd8, "R9 starvation grant t0");
      expect_g(4'b0010, 4'd8, "R9 back to t1");

      // R10: nothing valid in count priority
      thr_valid = 4'b0000;
      expect_g(4'b0000, 4'd0, "R10 no valid thread");

      step();
      summary();
      $finish;
   end

endmodule